// File: doc/BRIEF.md
# UART Prioritized Interrupt Controller

This block gathers the interrupt sources of one UART channel, holds the event-type sources in sticky pending bits, masks every source with a locally held enable register, and picks the highest-priority source that is both pending and enabled. The chosen source appears as a 6-bit identification code. A single interrupt line is asserted while any enabled source is pending.

The receiver conditions (line error, receive timeout, receive data ready) arrive as levels, and their owners clear them. The transmit-empty, modem-change, Xoff-received and flow-pin-change conditions arrive as one-cycle pulses. This block latches those four and clears them on the register accesses that acknowledge them: an identification read, a transmit-holding write, or a modem-status read. The detection logic behind each source belongs to other blocks. This controller only receives their outputs.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, `iir_o` reads 6'b000001 and `irq_o` is low.
- R2: `iir_o[0]` is 0 exactly when some enabled source is pending, and `irq_o` is high exactly then.
- R3: An enable-register write updates bits 7:5 and 3:0 unconditionally. Bit 4 (sleep enable, driven on `sleep_en_o`) changes only when `enh_en_i` is high during the write.
- R4: Each source is reported only while its enable bit is set. Bit 2 enables line error, bit 0 enables receive data and receive timeout, bit 1 enables transmit empty, bit 3 enables modem change and bit 5 enables Xoff.
- R5: With all enable bits cleared, `irq_o` stays low and `iir_o` reads 6'b000001, whatever the sources do.
- R6: Priority runs from highest to lowest as line error, receive timeout, receive data, transmit empty, modem change, Xoff, flow-pin change. The `iir_o` codes are 000110, 001100, 000100, 000010, 000000, 010000 and 100000 in the same order.
- R7: An Xoff pulse sets a pending bit. An identification read (`iir_rd_i`) clears it only while Xoff is the reported source.
- R8: A transmit-empty pulse sets a pending bit. It is cleared by a transmit-holding write (`thr_wr_i`), or by an identification read while transmit empty is the reported source. An identification read while another source is reported leaves it pending.
- R9: Modem-change, CTS-change and RTS-change pending bits are set by their pulses and cleared by a modem-status read (`msr_rd_i`).
- R10: When a set pulse and a clearing access arrive in the same cycle, the pending bit stays set.
- R11: The flow-pin-change source is reported when a CTS change is pending with enable bit 7 set, or an RTS change is pending with enable bit 6 set. A pending change whose enable is clear is held and not reported until that enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ier_we_i | input | 1 | Enable-register write strobe |
| ier_wdata_i | input | 8 | Enable-register write data |
| enh_en_i | input | 1 | Enhanced-functions bit, unlocks enable bit 4 |
| ls_err_i | input | 1 | Line error level |
| rx_tmo_i | input | 1 | Receive timeout level |
| rx_rdy_i | input | 1 | Receive data ready level |
| thr_evt_i | input | 1 | Transmit-empty event pulse |
| thr_wr_i | input | 1 | Transmit-holding write strobe |
| mdm_evt_i | input | 1 | Modem-status change pulse |
| msr_rd_i | input | 1 | Modem-status read strobe |
| xoff_evt_i | input | 1 | Xoff character received pulse |
| cts_evt_i | input | 1 | CTS pin change pulse |
| rts_evt_i | input | 1 | RTS pin change pulse |
| iir_rd_i | input | 1 | Identification-register read strobe |
| ier_o | output | 8 | Enable register contents |
| sleep_en_o | output | 1 | Sleep-mode enable (enable bit 4) |
| iir_o | output | 6 | Identification code of the reported source |
| irq_o | output | 1 | Interrupt output |

## Verification
The assertions check four things on every cycle. The interrupt line must agree with identification bit 0. An enable register of zero must keep the line quiet. An enabled line error must always win. The sleep bit must never move while the enhanced bit is low. They also check that a reported Xoff or transmit-empty condition is gone one cycle after its acknowledging access. The bench scenarios cover what needs a history of events: the full priority walk-down as sources retire one by one, latched flow-pin changes becoming visible only when their enable is set, reads that must not clear a source that is not reported, and the same-cycle set-versus-clear collisions.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 7;
  localparam int IIR_W   = 6;
  localparam int IER_W   = 8;

  // index = priority rank, 0 highest
  localparam int IDX_LS   = 0;
  localparam int IDX_TMO  = 1;
  localparam int IDX_RX   = 2;
  localparam int IDX_THR  = 3;
  localparam int IDX_MDM  = 4;
  localparam int IDX_XOFF = 5;
  localparam int IDX_FLOW = 6;

  // enable bit positions
  localparam int EN_RX    = 0;
  localparam int EN_THR   = 1;
  localparam int EN_LS    = 2;
  localparam int EN_MDM   = 3;
  localparam int EN_SLEEP = 4;
  localparam int EN_XOFF  = 5;
  localparam int EN_RTS   = 6;
  localparam int EN_CTS   = 7;

  localparam logic [IIR_W-1:0] CODE_NONE = 6'b000001;
  localparam logic [IIR_W-1:0] CODE_LS   = 6'b000110;
  localparam logic [IIR_W-1:0] CODE_TMO  = 6'b001100;
  localparam logic [IIR_W-1:0] CODE_RX   = 6'b000100;
  localparam logic [IIR_W-1:0] CODE_THR  = 6'b000010;
  localparam logic [IIR_W-1:0] CODE_MDM  = 6'b000000;
  localparam logic [IIR_W-1:0] CODE_XOFF = 6'b010000;
  localparam logic [IIR_W-1:0] CODE_FLOW = 6'b100000;

  function automatic logic [IIR_W-1:0] src_code(input int idx);
    case (idx)
      IDX_LS:   src_code = CODE_LS;
      IDX_TMO:  src_code = CODE_TMO;
      IDX_RX:   src_code = CODE_RX;
      IDX_THR:  src_code = CODE_THR;
      IDX_MDM:  src_code = CODE_MDM;
      IDX_XOFF: src_code = CODE_XOFF;
      default:  src_code = CODE_FLOW;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg #(
  parameter int W        = 8,
  parameter int LOCK_BIT = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         unlock_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] wmask;

  always_comb begin
    wmask           = '1;
    wmask[LOCK_BIT] = unlock_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= (wdata_i & wmask) | (q_o & ~wmask);
  end
endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IIR_W-1:0] code_o,
  output logic             any_o
);
  logic [N:0]           blocked;
  logic [IIR_W-1:0]     term [N];

  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_rank
    assign blocked[i+1] = blocked[i] | req_i[i];
    assign grant_o[i]   = req_i[i] & ~blocked[i];
    assign term[i]      = grant_o[i] ? src_code(i) : '0;
  end

  assign any_o = blocked[N];

  always_comb begin
    code_o = '0;
    for (int i = 0; i < N; i++) code_o = code_o | term[i];
    if (!any_o) code_o = CODE_NONE;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ier_we_i,
  input  logic [IER_W-1:0] ier_wdata_i,
  input  logic             enh_en_i,
  input  logic             ls_err_i,
  input  logic             rx_tmo_i,
  input  logic             rx_rdy_i,
  input  logic             thr_evt_i,
  input  logic             thr_wr_i,
  input  logic             mdm_evt_i,
  input  logic             msr_rd_i,
  input  logic             xoff_evt_i,
  input  logic             cts_evt_i,
  input  logic             rts_evt_i,
  input  logic             iir_rd_i,
  output logic [IER_W-1:0] ier_o,
  output logic             sleep_en_o,
  output logic [IIR_W-1:0] iir_o,
  output logic             irq_o
);
  logic [NUM_SRC-1:0] req, grant;
  logic thr_p, mdm_p, xoff_p, cts_p, rts_p;
  logic thr_clr, xoff_clr;

  uart_irq_enable_reg #(.W(IER_W), .LOCK_BIT(EN_SLEEP)) u_ier (
    .clk_i, .rst_ni,
    .we_i     (ier_we_i),
    .wdata_i  (ier_wdata_i),
    .unlock_i (enh_en_i),
    .q_o      (ier_o)
  );

  assign sleep_en_o = ier_o[EN_SLEEP];

  // acknowledge only the source currently reported
  assign thr_clr  = thr_wr_i | (iir_rd_i & grant[IDX_THR]);
  assign xoff_clr = iir_rd_i & grant[IDX_XOFF];

  uart_irq_sticky u_thr  (.clk_i, .rst_ni, .set_i(thr_evt_i),  .clr_i(thr_clr),  .q_o(thr_p));
  uart_irq_sticky u_mdm  (.clk_i, .rst_ni, .set_i(mdm_evt_i),  .clr_i(msr_rd_i), .q_o(mdm_p));
  uart_irq_sticky u_xoff (.clk_i, .rst_ni, .set_i(xoff_evt_i), .clr_i(xoff_clr), .q_o(xoff_p));
  uart_irq_sticky u_cts  (.clk_i, .rst_ni, .set_i(cts_evt_i),  .clr_i(msr_rd_i), .q_o(cts_p));
  uart_irq_sticky u_rts  (.clk_i, .rst_ni, .set_i(rts_evt_i),  .clr_i(msr_rd_i), .q_o(rts_p));

  always_comb begin
    req           = '0;
    req[IDX_LS]   = ls_err_i & ier_o[EN_LS];
    req[IDX_TMO]  = rx_tmo_i & ier_o[EN_RX];
    req[IDX_RX]   = rx_rdy_i & ier_o[EN_RX];
    req[IDX_THR]  = thr_p    & ier_o[EN_THR];
    req[IDX_MDM]  = mdm_p    & ier_o[EN_MDM];
    req[IDX_XOFF] = xoff_p   & ier_o[EN_XOFF];
    req[IDX_FLOW] = (cts_p & ier_o[EN_CTS]) | (rts_p & ier_o[EN_RTS]);
  end

  uart_irq_prio #(.N(NUM_SRC)) u_prio (
    .req_i   (req),
    .grant_o (grant),
    .code_o  (iir_o),
    .any_o   (irq_o)
  );
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
  import uart_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ier_we_i,
  input logic             enh_en_i,
  input logic             ls_err_i,
  input logic             thr_wr_i,
  input logic             thr_evt_i,
  input logic             xoff_evt_i,
  input logic             iir_rd_i,
  input logic [IER_W-1:0] ier_o,
  input logic [IIR_W-1:0] iir_o,
  input logic             irq_o
);
  p_irq_matches_id_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == !iir_o[0]);

  p_all_masked_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_o == '0) |-> (!irq_o && iir_o == CODE_NONE));

  p_line_err_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ls_err_i && ier_o[EN_LS]) |-> (iir_o == CODE_LS));

  p_sleep_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_we_i && !enh_en_i) |=> $stable(ier_o[EN_SLEEP]));

  p_xoff_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && iir_o == CODE_XOFF && !xoff_evt_i) |=> (iir_o != CODE_XOFF));

  p_thr_write_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_wr_i && !thr_evt_i) |=> (iir_o != CODE_THR));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk u_chk (.*);

// File: tb/uart_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ier_we = 0, enh = 0;
  logic [7:0] ier_wd = '0;
  logic ls = 0, tmo = 0, rdy = 0, thr_evt = 0, thr_wr = 0, mdm_evt = 0, msr_rd = 0;
  logic xoff_evt = 0, cts_evt = 0, rts_evt = 0, iir_rd = 0;
  logic [7:0] ier;
  logic sleep_en, irq;
  logic [5:0] iir;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ier_we_i(ier_we), .ier_wdata_i(ier_wd), .enh_en_i(enh),
    .ls_err_i(ls), .rx_tmo_i(tmo), .rx_rdy_i(rdy), .thr_evt_i(thr_evt), .thr_wr_i(thr_wr),
    .mdm_evt_i(mdm_evt), .msr_rd_i(msr_rd), .xoff_evt_i(xoff_evt), .cts_evt_i(cts_evt),
    .rts_evt_i(rts_evt), .iir_rd_i(iir_rd), .ier_o(ier), .sleep_en_o(sleep_en),
    .iir_o(iir), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // full cycle then sample just after the negedge
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr_ier(input logic [7:0] v, input logic unlock);
    ier_we = 1; ier_wd = v; enh = unlock;
    step();
    ier_we = 0; enh = 0;
  endtask

  task automatic chk_id(input string tag, input logic [5:0] code);
    chk({tag, " iir"}, {2'b0, iir}, {2'b0, code});
    chk({tag, " irq"}, {7'b0, irq}, {7'b0, code != 6'b000001});
  endtask

  task automatic t_reset();
    chk("R1 ier", ier, 8'h00);
    chk_id("R1", 6'b000001);
  endtask

  task automatic t_ier_lock();
    wr_ier(8'hFF, 1'b0);
    chk("R3 locked write", ier, 8'hEF);
    chk("R3 sleep locked", {7'b0, sleep_en}, 8'h00);
    wr_ier(8'hFF, 1'b1);
    chk("R3 unlocked write", ier, 8'hFF);
    wr_ier(8'h00, 1'b0);
    chk("R3 sleep kept", ier, 8'h10);
    wr_ier(8'h00, 1'b1);
    chk("R3 cleared", ier, 8'h00);
  endtask

  task automatic t_mask();
    ls = 1; tmo = 1; rdy = 1;
    step();
    chk_id("R5 all masked", 6'b000001);
    wr_ier(8'h04, 1'b0);
    chk_id("R4 ls only", 6'b000110);
    wr_ier(8'h01, 1'b0);
    chk_id("R4 rx enable gives tmo", 6'b001100);
    ls = 0; tmo = 0; rdy = 0;
    wr_ier(8'h00, 1'b0);
  endtask

  task automatic t_priority();
    wr_ier(8'hEF, 1'b0);
    ls = 1; tmo = 1; rdy = 1;
    thr_evt = 1; mdm_evt = 1; xoff_evt = 1; cts_evt = 1;
    step();
    thr_evt = 0; mdm_evt = 0; xoff_evt = 0; cts_evt = 0;
    chk_id("R6 ls top", 6'b000110);
    ls = 0; #1;
    chk_id("R6 tmo", 6'b001100);
    tmo = 0; #1;
    chk_id("R6 rx", 6'b000100);
    rdy = 0; #1;
    chk_id("R6 thr", 6'b000010);
    thr_wr = 1; step(); thr_wr = 0;
    chk_id("R8 thr write clears", 6'b000000);
    msr_rd = 1; step(); msr_rd = 0;
    chk_id("R9 msr read clears modem and cts", 6'b010000);
    iir_rd = 1; step(); iir_rd = 0;
    chk_id("R7 xoff cleared by read", 6'b000001);
    rts_evt = 1; step(); rts_evt = 0;
    chk_id("R6 flow code", 6'b100000);
    msr_rd = 1; step(); msr_rd = 0;
    chk_id("R9 rts cleared", 6'b000001);
  endtask

  task automatic t_flow_enable();
    wr_ier(8'h40, 1'b0);
    cts_evt = 1; step(); cts_evt = 0;
    chk_id("R11 cts masked by bit7", 6'b000001);
    wr_ier(8'h80, 1'b0);
    chk_id("R11 cts held then shown", 6'b100000);
    msr_rd = 1; step(); msr_rd = 0;
    chk_id("R11 cleared", 6'b000001);
    wr_ier(8'h00, 1'b0);
  endtask

  task automatic t_thr_read();
    wr_ier(8'h06, 1'b0);
    ls = 1; thr_evt = 1; step(); thr_evt = 0;
    chk_id("R8 ls hides thr", 6'b000110);
    iir_rd = 1; step(); iir_rd = 0;
    ls = 0; #1;
    chk_id("R8 unreported thr survives read", 6'b000010);
    iir_rd = 1; step(); iir_rd = 0;
    chk_id("R8 reported thr cleared by read", 6'b000001);
  endtask

  task automatic t_xoff_read();
    wr_ier(8'h24, 1'b0);
    ls = 1; xoff_evt = 1; step(); xoff_evt = 0;
    iir_rd = 1; step(); iir_rd = 0;
    ls = 0; #1;
    chk_id("R7 unreported xoff survives", 6'b010000);
    iir_rd = 1; xoff_evt = 1; step(); iir_rd = 0; xoff_evt = 0;
    chk_id("R10 xoff set beats read", 6'b010000);
    iir_rd = 1; step(); iir_rd = 0;
    chk_id("R7 xoff cleared", 6'b000001);
  endtask

  task automatic t_collide();
    wr_ier(8'h0A, 1'b0);
    thr_evt = 1; step(); thr_evt = 0;
    thr_wr = 1; thr_evt = 1; step(); thr_wr = 0; thr_evt = 0;
    chk_id("R10 thr set beats write", 6'b000010);
    thr_wr = 1; step(); thr_wr = 0;
    mdm_evt = 1; msr_rd = 1; step(); mdm_evt = 0; msr_rd = 0;
    chk_id("R10 modem set beats read", 6'b000000);
    msr_rd = 1; step(); msr_rd = 0;
    chk_id("R9 modem cleared", 6'b000001);
    wr_ier(8'h00, 1'b0);
    chk("R2 idle irq low", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_ier_lock();
    t_mask();
    t_priority();
    t_flow_enable();
    t_thr_read();
    t_xoff_read();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule